// File: doc/BRIEF.md
# Nine-Bit Serial Register Writer

This block sends register-write transactions to a display controller over a three-wire serial link: an active-low select, a clock and a data line. Each word on the wire is 9 bits. The first bit out is a flag that is 0 for a register address and 1 for a data byte, and the 8 payload bits follow, most significant first. One request names a register address, a byte count (0, 1 or 2) and a 16-bit value. The block sends the address word and then the data words, all inside a single select window.

A host presents a request with `req_valid` and holds it until `req_ready` is seen high at a clock edge. The block copies the request fields at that edge. `req_ready` then stays low until the transaction has finished and the select line has been idle for a while. A one-cycle `done` pulse marks the end. The serial clock runs at the system clock divided by the even parameter `CLK_DIV`. Every timed step of the sequence lasts one half period, which is `CLK_DIV/2` system cycles.

The controller has seven states. IDLE goes to SETUP when a request is accepted. SETUP goes to LOW after one half period. LOW goes to HIGH after one half period. HIGH goes back to LOW for the next bit or the next word, or to TAIL after bit 0 of the last word. TAIL goes to GAP after one half period, and GAP goes to DONE after one half period. DONE returns to IDLE after one cycle.

Top module: `ninebit_cmd_writer`

## Requirements
- R1: Each word is shifted out most significant bit first. Bit 8 is the flag (0 = address word, 1 = data word) and bits 7..0 are the payload. `spi_mosi` is 0 whenever no bit is being driven.
- R2: A byte count of 0 sends only the address word. A count of 1 sends two words and a count of 2 sends three words. The count value 3 is handled like 2.
- R3: With one data byte, the payload is `req_value[7:0]`. With two data bytes, the first data word carries `req_value[15:8]` and the second carries `req_value[7:0]`.
- R4: The clock idles high. For each bit it is low for one half period and then high for one half period. The data line changes only at the start of the low phase, so it is stable across the rising edge.
- R5: The select goes low one half period before the first falling clock edge. It stays low across all words of the transaction and rises one half period after the last rising clock edge, while the clock is high.
- R6: After the select rises, it stays high for one half period before the done pulse.
- R7: `req_ready` is high in IDLE and low from the acceptance edge through the DONE cycle. `done` is high for exactly one cycle, at the end of GAP, and `req_ready` returns in the next cycle.
- R8: A request that is presented while the block is busy is held off and accepted in the first cycle that IDLE is shown. The request fields are used only at the acceptance edge, and changes while `req_valid` is low have no effect.
- R9: After reset: `spi_csn` = 1, `spi_sclk` = 1, `spi_mosi` = 0, `req_ready` = 1, `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | DATA_W | Register address, sent in the address word |
| req_count | input | $clog2(MAX_BYTES+1) | Number of data bytes |
| req_value | input | DATA_W*MAX_BYTES | Data value, high byte first on the wire |
| done | output | 1 | One-cycle end-of-transaction pulse |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_csn | output | 1 | Active-low select |
| spi_mosi | output | 1 | Serial data out |

## Verification
The hardest case to reach is a new request that waits while a transfer is running and carries fields different from the transfer in progress. That case shows whether the block uses the captured copy or the live inputs, and whether it accepts the waiting request in the first IDLE cycle. The stimulus raises the next request in the same cycle as the previous acceptance, so requests queue back to back. Between requests, the fields change randomly while `req_valid` is low. The list of requests includes the count value 3, all-ones and all-zeros values, and a one-byte request whose upper value byte must not appear on the wire.

// File: rtl/nbw_pkg.sv
package nbw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_GAP,
        ST_DONE
    } nbw_state_e;

    localparam logic FLAG_ADDR = 1'b0;
    localparam logic FLAG_DATA = 1'b1;

endpackage

// File: rtl/nbw_halftick.sv
module nbw_halftick #(
    parameter int HALF = 2,
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    halftick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/nbw_word_builder.sv
module nbw_word_builder
    import nbw_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 2,
    localparam int WORD_W = DATA_W + 1,
    localparam int VAL_W  = DATA_W * MAX_BYTES,
    localparam int CNT_W  = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [VAL_W-1:0]  value_i,
    input  logic [CNT_W-1:0]  sel_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  last_o
);
    localparam logic [CNT_W-1:0] MAX_IDX = CNT_W'(MAX_BYTES);

    logic [DATA_W-1:0] addr_q;
    logic [VAL_W-1:0]  value_q;
    logic [CNT_W-1:0]  last_q;
    logic [CNT_W-1:0]  last_d;
    logic [WORD_W-1:0] word_tab [MAX_BYTES+1];

    assign last_d = (count_i > MAX_IDX) ? MAX_IDX : count_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            value_q <= '0;
            last_q  <= '0;
        end else if (load) begin
            addr_q  <= addr_i;
            value_q <= value_i;
            last_q  <= last_d;
        end
    end

    // word k (k >= 1) carries byte (last - k): high byte goes first
    always_comb begin
        word_tab[0] = {FLAG_ADDR, addr_q};
        for (int k = 1; k <= MAX_BYTES; k++) begin
            word_tab[k] = {FLAG_DATA, {DATA_W{1'b0}}};
            for (int j = 0; j < MAX_BYTES; j++) begin
                if (int'(last_q) - k == j) begin
                    word_tab[k][DATA_W-1:0] = value_q[j*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_comb begin
        word_o = '0;
        for (int k = 0; k <= MAX_BYTES; k++) begin
            if (int'(sel_i) == k) begin
                word_o = word_tab[k];
            end
        end
    end

    assign last_o = last_q;

    // R2
    last_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (last_o <= MAX_IDX));

endmodule

// File: rtl/nbw_sequencer.sv
module nbw_sequencer
    import nbw_pkg::*;
#(
    parameter int WORD_W = 9,
    parameter int CNT_W  = 2,
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             tick,
    input  logic [CNT_W-1:0] last_i,
    output logic             req_ready,
    output logic             load_o,
    output logic             done_o,
    output logic             sclk_o,
    output logic             csn_o,
    output logic             bit_en_o,
    output logic             run_o,
    output logic [CNT_W-1:0] word_idx_o,
    output logic [BIT_W-1:0] bit_idx_o
);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

    nbw_state_e       state_q, state_d;
    logic [CNT_W-1:0] widx_q, widx_d;
    logic [BIT_W-1:0] bidx_q, bidx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            widx_q  <= '0;
            bidx_q  <= '0;
        end else begin
            state_q <= state_d;
            widx_q  <= widx_d;
            bidx_q  <= bidx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        widx_d  = widx_q;
        bidx_d  = bidx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_SETUP;
                    widx_d  = '0;
                    bidx_d  = TOP_BIT;
                end
            end
            ST_SETUP: begin
                if (tick) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (tick) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (tick) begin
                    if (bidx_q == '0) begin
                        if (widx_q == last_i) begin
                            state_d = ST_TAIL;
                        end else begin
                            widx_d  = widx_q + 1'b1;
                            bidx_d  = TOP_BIT;
                            state_d = ST_LOW;
                        end
                    end else begin
                        bidx_d  = bidx_q - 1'b1;
                        state_d = ST_LOW;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (tick) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        load_o    = 1'b0;
        done_o    = 1'b0;
        sclk_o    = 1'b1;
        csn_o     = 1'b1;
        bit_en_o  = 1'b0;
        run_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                load_o    = req_valid;
            end
            ST_SETUP: begin
                csn_o = 1'b0;
                run_o = 1'b1;
            end
            ST_LOW: begin
                csn_o    = 1'b0;
                sclk_o   = 1'b0;
                bit_en_o = 1'b1;
                run_o    = 1'b1;
            end
            ST_HIGH: begin
                csn_o    = 1'b0;
                bit_en_o = 1'b1;
                run_o    = 1'b1;
            end
            ST_TAIL: begin
                csn_o = 1'b0;
                run_o = 1'b1;
            end
            ST_GAP: begin
                run_o = 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign word_idx_o = widx_q;
    assign bit_idx_o  = bidx_q;

    // R7
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && req_ready));

    // R5
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_o) |-> (sclk_o && $past(sclk_o)));

    // R4
    fall_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> !csn_o);

    // R2
    word_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (widx_q <= last_i));

endmodule

// File: rtl/ninebit_cmd_writer.sv
module ninebit_cmd_writer #(
    parameter int CLK_DIV   = 4,
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 2,
    localparam int HALF   = CLK_DIV / 2,
    localparam int WORD_W = DATA_W + 1,
    localparam int VAL_W  = DATA_W * MAX_BYTES,
    localparam int CNT_W  = $clog2(MAX_BYTES + 1),
    localparam int BIT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [VAL_W-1:0]  req_value,
    output logic              done,
    output logic              spi_sclk,
    output logic              spi_csn,
    output logic              spi_mosi
);
    logic              tick;
    logic              run;
    logic              load;
    logic              bit_en;
    logic [CNT_W-1:0]  last_idx;
    logic [CNT_W-1:0]  word_idx;
    logic [BIT_W-1:0]  bit_idx;
    logic [WORD_W-1:0] cur_word;

    nbw_halftick #(.HALF(HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    nbw_word_builder #(.DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)) u_words (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .addr_i (req_addr),
        .count_i(req_count),
        .value_i(req_value),
        .sel_i  (word_idx),
        .word_o (cur_word),
        .last_o (last_idx)
    );

    nbw_sequencer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .tick      (tick),
        .last_i    (last_idx),
        .req_ready (req_ready),
        .load_o    (load),
        .done_o    (done),
        .sclk_o    (spi_sclk),
        .csn_o     (spi_csn),
        .bit_en_o  (bit_en),
        .run_o     (run),
        .word_idx_o(word_idx),
        .bit_idx_o (bit_idx)
    );

    assign spi_mosi = bit_en && cur_word[bit_idx];

    // R1
    mosi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !spi_mosi);

    // R4
    mosi_stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) && !spi_csn |-> $stable(spi_mosi));

endmodule

// File: tb/sim_ninebit_cmd_writer.sv
module sim_ninebit_cmd_writer;
    localparam int CLK_DIV  = 4;
    localparam int HALF     = CLK_DIV / 2;
    localparam int NREQ     = 8;
    localparam int WATCHDOG = 20000;
    localparam logic [4:0] IDLE_V = 5'b11010; // csn sclk mosi ready done

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [7:0]  req_addr;
    logic [1:0]  req_count;
    logic [15:0] req_value;
    logic        done;
    logic        spi_sclk, spi_csn, spi_mosi;

    int vectors = 0;
    int miscompares = 0;
    logic [4:0] exp_q[$];

    always #5 clk = ~clk;

    ninebit_cmd_writer #(.CLK_DIV(CLK_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_count(req_count), .req_value(req_value),
        .done(done), .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi)
    );

    logic [7:0]  t_addr  [NREQ] = '{8'h00, 8'hB0, 8'hB8, 8'h5A, 8'h11, 8'hFF, 8'h00, 8'h3C};
    logic [1:0]  t_count [NREQ] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd2, 2'd2, 2'd1};
    logic [15:0] t_value [NREQ] = '{16'h1234, 16'h0017, 16'hFFF9, 16'hA55A,
                                    16'hFFFF, 16'h0000, 16'hFFFF, 16'hAB80};
    int          t_gap   [NREQ] = '{2, 0, 5, 0, 0, 3, 0, 1};

    // R2 R3: word list from count and value; R4 R5 R6 R7: per-cycle line levels
    task automatic push_txn(input logic [7:0] a, input logic [1:0] c, input logic [15:0] v);
        int nb;
        logic [8:0] w [3];
        nb = (c > 2'd2) ? 2 : int'(c);
        w[0] = {1'b0, a};
        w[1] = {1'b1, (nb == 2) ? v[15:8] : v[7:0]};
        w[2] = {1'b1, v[7:0]};
        repeat (HALF) exp_q.push_back(5'b01000);
        for (int k = 0; k <= nb; k++) begin
            for (int b = 8; b >= 0; b--) begin
                repeat (HALF) exp_q.push_back({2'b00, w[k][b], 2'b00});
                repeat (HALF) exp_q.push_back({2'b01, w[k][b], 2'b00});
            end
        end
        repeat (HALF) exp_q.push_back(5'b01000);
        repeat (HALF) exp_q.push_back(5'b11000);
        exp_q.push_back(5'b11001);
    endtask

    task automatic cmp(input logic [4:0] e, input string ctx);
        logic [4:0] g;
        g = {spi_csn, spi_sclk, spi_mosi, req_ready, done};
        vectors++;
        if (g[4] !== e[4]) begin miscompares++;
            $display("FAIL %s R5/R6 csn got %b exp %b t=%0t", ctx, g[4], e[4], $time); end
        if (g[3] !== e[3]) begin miscompares++;
            $display("FAIL %s R4 sclk got %b exp %b t=%0t", ctx, g[3], e[3], $time); end
        if (g[2] !== e[2]) begin miscompares++;
            $display("FAIL %s R1/R2/R3 mosi got %b exp %b t=%0t", ctx, g[2], e[2], $time); end
        if (g[1] !== e[1]) begin miscompares++;
            $display("FAIL %s R7/R8 ready got %b exp %b t=%0t", ctx, g[1], e[1], $time); end
        if (g[0] !== e[0]) begin miscompares++;
            $display("FAIL %s R7 done got %b exp %b t=%0t", ctx, g[0], e[0], $time); end
    endtask

    initial begin
        int idx, gap, seed;
        bit accepted, finished;
        logic [4:0] e;
        rst_n = 1'b0; req_valid = 1'b0;
        req_addr = '0; req_count = '0; req_value = '0;
        idx = 0; gap = t_gap[0]; accepted = 0; finished = 0; seed = 32'h1F2E3D;
        repeat (3) @(negedge clk);
        cmp(IDLE_V, "R9 reset");
        rst_n = 1'b1;
        for (int cyc = 0; cyc < WATCHDOG && !finished; cyc++) begin
            @(negedge clk);
            e = (exp_q.size() != 0) ? exp_q.pop_front() : IDLE_V;
            cmp(e, "run");
            if (accepted) begin
                accepted = 0;
                req_valid = 1'b0;
                if (idx < NREQ) gap = t_gap[idx];
            end
            if (!req_valid) begin
                if (idx < NREQ && gap == 0) begin
                    // R8: next request raised while busy, held until accepted
                    req_addr  = t_addr[idx];
                    req_count = t_count[idx];
                    req_value = t_value[idx];
                    req_valid = 1'b1;
                end else begin
                    if (gap > 0) gap--;
                    // R8: field changes with valid low must have no effect
                    seed = seed * 1103515245 + 12345;
                    req_addr  = seed[23:16];
                    req_count = seed[9:8];
                    req_value = seed[31:16] ^ seed[15:0];
                end
            end
            if (req_valid && e[1]) begin
                push_txn(req_addr, req_count, req_value);
                idx++;
                accepted = 1;
            end
            if (idx == NREQ && !accepted && !req_valid && exp_q.size() == 0) finished = 1;
        end
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog R7 got hung exp finished");
        end else begin
            repeat (3) begin
                @(negedge clk);
                cmp(IDLE_V, "R7 idle after");
            end
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule